// File: doc/BRIEF.md
# Single-Level Interrupt Front End

This block sits between one interrupt-requesting device and the next-address logic of a single-cycle processor. An asynchronous request from the device is brought into the clock domain through a short synchronizer chain. When the synchronized request is high and interrupts are not masked, the block raises a one-cycle alert to the processor. It also asserts an acknowledge back to the device so the device can drop its request, and it masks further interrupts.

The mask and the acknowledge are each held in a set/reset flip-flop. Software clears the mask with an enable strobe and sets it with a disable strobe. The processor can also return a handled strobe, which withdraws the acknowledge early. While the alert is high, the next-PC multiplexer steers to a fixed handler address. Otherwise it selects one of four ordinary sources: the incremented PC, the jump target, the register target or the system-call entry.

Top module: `irq_front`

## Requirements
- R1: After reset the acknowledge and the alert are low and interrupts are masked, so a request raised before any enable strobe produces neither an alert nor an acknowledge.
- R2: The request passes through SYNC_STAGES flip-flops (default 2) before it is used. A request driven before clock edge k raises the alert after edge k+SYNC_STAGES-1 and not earlier.
- R3: The alert is high for exactly one cycle per accepted interrupt. That is the first cycle in which the synchronized request is high while the mask is clear.
- R4: Accepting an interrupt sets the mask from the next edge onward. No further alert occurs, whether the request is held or raised again, until an enable strobe clears the mask.
- R5: The acknowledge rises on the edge that ends the alert cycle. It stays high while the synchronized request stays high.
- R6: The acknowledge falls on the first edge at which the synchronized request is low, or at which the handled strobe is high, unless an interrupt is accepted on that edge.
- R7: An enable strobe clears the mask and a disable strobe sets it. When both strobes arrive in the same cycle, the disable wins and the mask ends up set.
- R8: While the alert is high, next_pc_o equals HANDLER_PC. Otherwise pc_sel_i chooses the output: 0 gives the incremented PC, 1 the jump target, 2 the register target and 3 SYSCALL_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 1 | Asynchronous device interrupt request |
| int_en_i | input | 1 | Software strobe that clears the mask |
| int_dis_i | input | 1 | Software strobe that sets the mask |
| int_done_i | input | 1 | Processor strobe that withdraws the acknowledge |
| pc_sel_i | input | 2 | Ordinary next-PC source select |
| pc_incr_i | input | PC_W | Incremented PC |
| jump_tgt_i | input | PC_W | Jump target |
| reg_tgt_i | input | PC_W | Register target |
| int_ack_o | output | 1 | Acknowledge to the device |
| int_alert_o | output | 1 | Interrupt alert to the next-address logic |
| next_pc_o | output | PC_W | Selected next PC |

## Verification
The assertions assume that the enable and disable strobes, the handled strobe and the PC select are synchronous to the clock and stable around its edge. Only the device request may change at arbitrary times. The stimulus drives every input, the request included, on the falling edge. Each request is held low long enough to pass the synchronizer before the next one, so every timing claim about a request edge can be counted exactly from the falling edge that drove it. The strobes are held for exactly one cycle, so the same-cycle priority case arises only where a test places it on purpose.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    PC_SEL_INCR    = 2'd0,
    PC_SEL_JUMP    = 2'd1,
    PC_SEL_REG     = 2'd2,
    PC_SEL_SYSCALL = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sr_ctl.sv
module irq_sr_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic en_i,
  input  logic dis_i,
  input  logic done_i,
  output logic alert_o,
  output logic ack_o
);
  logic mask_q, ack_q;
  logic accept;

  // gated request: synchronized and not masked
  assign accept = req_s_i & ~mask_q;

  // mask flop: disable > accept > enable; reset masked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             mask_q <= 1'b1;
    else if (dis_i || accept) mask_q <= 1'b1;
    else if (en_i)           mask_q <= 1'b0;
  end

  // acknowledge flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ack_q <= 1'b0;
    else if (accept)             ack_q <= 1'b1;
    else if (!req_s_i || done_i) ack_q <= 1'b0;
  end

  assign alert_o = accept;
  assign ack_o   = ack_q;

  p_alert_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> !alert_o);
  p_accept_masks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> mask_q);
  p_ack_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> ack_o);
  p_ack_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_o && (!req_s_i || done_i)) |=> !ack_o);
  p_dis_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> mask_q);
  p_en_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dis_i && !alert_o) |=> !mask_q);
endmodule

// File: rtl/irq_next_pc.sv
module irq_next_pc
  import irq_pkg::*;
#(
  parameter int unsigned      PC_W       = 30,
  parameter logic [PC_W-1:0]  HANDLER_PC = '0,
  parameter logic [PC_W-1:0]  SYSCALL_PC = '0
) (
  input  logic            alert_i,
  input  logic [1:0]      sel_i,
  input  logic [PC_W-1:0] incr_i,
  input  logic [PC_W-1:0] jump_i,
  input  logic [PC_W-1:0] reg_i,
  output logic [PC_W-1:0] next_pc_o
);
  logic [PC_W-1:0] base_pc;

  always_comb begin
    unique case (pc_sel_e'(sel_i))
      PC_SEL_INCR:    base_pc = incr_i;
      PC_SEL_JUMP:    base_pc = jump_i;
      PC_SEL_REG:     base_pc = reg_i;
      PC_SEL_SYSCALL: base_pc = SYSCALL_PC;
      default:        base_pc = incr_i;
    endcase
  end

  assign next_pc_o = alert_i ? HANDLER_PC : base_pc;
endmodule

// File: rtl/irq_front.sv
module irq_front #(
  parameter int unsigned     PC_W        = 30,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [PC_W-1:0] HANDLER_PC  = 30'h0020_0060,
  parameter logic [PC_W-1:0] SYSCALL_PC  = 30'h0010_0040
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_req_i,
  input  logic            int_en_i,
  input  logic            int_dis_i,
  input  logic            int_done_i,
  input  logic [1:0]      pc_sel_i,
  input  logic [PC_W-1:0] pc_incr_i,
  input  logic [PC_W-1:0] jump_tgt_i,
  input  logic [PC_W-1:0] reg_tgt_i,
  output logic            int_ack_o,
  output logic            int_alert_o,
  output logic [PC_W-1:0] next_pc_o
);
  logic req_s;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_req_i),
    .q_o    (req_s)
  );

  irq_sr_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_s_i (req_s),
    .en_i    (int_en_i),
    .dis_i   (int_dis_i),
    .done_i  (int_done_i),
    .alert_o (int_alert_o),
    .ack_o   (int_ack_o)
  );

  irq_next_pc #(
    .PC_W       (PC_W),
    .HANDLER_PC (HANDLER_PC),
    .SYSCALL_PC (SYSCALL_PC)
  ) u_npc (
    .alert_i   (int_alert_o),
    .sel_i     (pc_sel_i),
    .incr_i    (pc_incr_i),
    .jump_i    (jump_tgt_i),
    .reg_i     (reg_tgt_i),
    .next_pc_o (next_pc_o)
  );

  p_handler_steer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_alert_o |-> (next_pc_o == HANDLER_PC));
endmodule

// File: tb/irq_front_bench.sv
module irq_front_bench;
  localparam int unsigned PC_W = 30;
  localparam logic [PC_W-1:0] HANDLER = 30'h0020_0060;
  localparam logic [PC_W-1:0] SYSCALL = 30'h0010_0040;
  localparam logic [PC_W-1:0] INCR    = 30'h0000_1234;
  localparam logic [PC_W-1:0] JUMP    = 30'h0ABC_0000;
  localparam logic [PC_W-1:0] REGT    = 30'h0155_5555;

  // {sel[1:0], expected next pc}
  localparam logic [31:0] VEC [4] = '{
    {2'd2, 30'h0155_5555},
    {2'd0, 30'h0000_1234},
    {2'd3, 30'h0010_0040},
    {2'd1, 30'h0ABC_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, en = 1'b0, dis = 1'b0, done = 1'b0;
  logic [1:0] sel = 2'd0;
  logic ack, alert;
  logic [PC_W-1:0] npc;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_front u_irq_front (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .int_en_i(en),
    .int_dis_i(dis), .int_done_i(done), .pc_sel_i(sel),
    .pc_incr_i(INCR), .jump_tgt_i(JUMP), .reg_tgt_i(REGT),
    .int_ack_o(ack), .int_alert_o(alert), .next_pc_o(npc)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_en;
    en = 1'b1; nedge(1); en = 1'b0;
  endtask

  task automatic drop_req;
    req = 1'b0; nedge(4);
  endtask

  initial begin
    nedge(2);
    chk("R1 reset ack", {31'd0, ack}, 32'd0);
    chk("R1 reset alert", {31'd0, alert}, 32'd0);
    rst_n = 1'b1;
    nedge(1);
    // R1: masked out of reset
    req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      nedge(1);
      chk("R1 masked alert", {31'd0, alert}, 32'd0);
    end
    chk("R1 masked ack", {31'd0, ack}, 32'd0);
    drop_req();

    // accept path
    pulse_en();
    req = 1'b1;
    nedge(1);
    chk("R2 no alert before sync", {31'd0, alert}, 32'd0);
    nedge(1);
    chk("R3 alert raised", {31'd0, alert}, 32'd1);
    chk("R8 handler pc", {2'd0, npc}, {2'd0, HANDLER});
    chk("R5 ack not yet", {31'd0, ack}, 32'd0);
    nedge(1);
    chk("R3 alert one cycle", {31'd0, alert}, 32'd0);
    chk("R5 ack raised", {31'd0, ack}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      nedge(1);
      chk("R4 held req no alert", {31'd0, alert}, 32'd0);
      chk("R5 ack held", {31'd0, ack}, 32'd1);
    end
    req = 1'b0;
    nedge(2);
    chk("R6 ack before sync low", {31'd0, ack}, 32'd1);
    nedge(1);
    chk("R6 ack cleared", {31'd0, ack}, 32'd0);
    nedge(1);

    // R4: re-raise without enable
    req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      nedge(1);
      chk("R4 re-raise masked", {31'd0, alert}, 32'd0);
    end
    drop_req();

    // R7: both strobes same cycle -> masked
    en = 1'b1; dis = 1'b1; nedge(1); en = 1'b0; dis = 1'b0;
    req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      nedge(1);
      chk("R7 disable wins", {31'd0, alert}, 32'd0);
    end
    drop_req();

    // R7: enable then disable -> masked
    pulse_en();
    dis = 1'b1; nedge(1); dis = 1'b0;
    req = 1'b1;
    nedge(3);
    chk("R7 disable sets mask", {31'd0, alert}, 32'd0);
    drop_req();

    // R6: handled strobe withdraws ack while request held
    pulse_en();
    req = 1'b1;
    nedge(2);
    chk("R7 enable clears mask", {31'd0, alert}, 32'd1);
    nedge(1);
    chk("R5 ack up", {31'd0, ack}, 32'd1);
    done = 1'b1; nedge(1); done = 1'b0;
    chk("R6 handled clears ack", {31'd0, ack}, 32'd0);
    nedge(2);
    chk("R6 ack stays low", {31'd0, ack}, 32'd0);
    drop_req();

    // R8: ordinary mux sources
    foreach (VEC[k]) begin
      sel = VEC[k][31:30];
      #1;
      chk("R8 mux select", {2'd0, npc}, {2'd0, VEC[k][29:0]});
      nedge(1);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule